// File: doc/BRIEF.md
# Transmit descriptor ring engine

This block drains a circular list of 8-byte transmit descriptors kept in system memory and turns each one into a byte stream for a serial framer. Software fills a descriptor with a 13-bit byte count, a flags byte and a 32-bit buffer address. It then sets the ownership flag and writes the prompt register. The engine reads the descriptor. If the descriptor is owned, the engine fetches the payload word by word and sends it out one byte at a time with a last-byte marker. It then writes back only the flags byte, with ownership cleared, and raises an interrupt. After that it moves on to the next ring entry by itself.

Per-frame flags travel beside the bytes so the framer can suppress its CRC, corrupt it on purpose, or force an underrun. A skip flag retires a descriptor without sending any bytes. When the framer waits too long for data in the middle of a frame, the write-back records a hardware underrun. Clearing the enable bit lets the current descriptor finish, then parks the engine and returns the ring index to zero.

Descriptor word 0, read little-endian, holds the count in bits 12:0 and the flags in bits 31:24. Word 1 holds the buffer address. Flags bits: 7 = owned by hardware, 6 = no CRC, 5 = bad CRC, 3 = forced underrun, 2 = skip, 0 = hardware underrun (written back by the engine).

Top module: `txr_engine`

## Requirements
- R1: After reset there is no memory request, no output byte and no interrupt, `tx_active` is low and `ring_idx` is 0.
- R2: Register map (by `reg_addr`): 0 control, where bit 0 is transmit enable; 1 holds ring address bits 31:26 in data bits 5:0; 2 holds ring address bits 25:10 in data bits 15:0; 3 ring size; 4 prompt; 5 interrupt clear. Descriptor `i` is read at ring address + 512 + 8*i.
- R3: Descriptors are read only after a prompt write (any data) while enabled. If flags bit 7 (word 0 bit 31) is clear, no payload is fetched, nothing is written back, no interrupt is raised and the index does not move.
- R4: An owned descriptor sends exactly count bytes, the count being 13 bits from word 0 bits 12:0. The bytes come from consecutive addresses starting at the word 1 address, at any alignment, with byte lane k of a memory word being address offset k. `out_last` marks only the final byte. A byte is held while `out_ready` is low.
- R5: Write-back writes word 0 with byte enables 4'b1000 only. It clears bit 7 and keeps the other flag bits. The count bytes are left unchanged. `irq` rises after the write-back and falls after a write to register 5.
- R6: After a write-back the engine reads the next entry without a new prompt. It stops at the first entry whose bit 7 is clear.
- R7: Size code = register 3 bits 11:8. The ring holds (code+1)*4 entries (code 0 gives 4, code 3 gives 16, code 15 gives 64). After the last entry the index wraps to 0.
- R8: A descriptor with flags bit 2 set, or with a count of 0, sends no bytes but is still written back and raises `irq`.
- R9: Flags bit 6 drives `out_nocrc`, bit 5 drives `out_badcrc` and bit 3 drives `out_abort`, on every byte of that frame.
- R10: In mid-frame, if `out_ready` is high with no byte offered for UNDER_LIM (default 6) consecutive cycles, the written-back flags have bit 0 set.
- R11: Clearing the enable bit lets the current descriptor finish. The engine then fetches no further entry, `tx_active` falls and `ring_idx` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register select |
| reg_wdata | input | REG_DW | Register write data |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables |
| mem_ack | input | 1 | Request done; read data valid |
| mem_rdata | input | 32 | Read data |
| out_valid | output | 1 | Output byte offered |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the frame |
| out_nocrc | output | 1 | Frame sent without CRC |
| out_badcrc | output | 1 | Frame gets a corrupted CRC |
| out_abort | output | 1 | Framer must force an underrun |
| out_ready | input | 1 | Framer takes the byte |
| tx_active | output | 1 | Engine is not idle |
| ring_idx | output | 6 | Current ring entry |
| irq | output | 1 | Descriptor-done interrupt |

## Verification
A prompt write is captured at the edge that ends the write. The descriptor read starts one cycle later. Each memory word takes the acknowledge latency plus one cycle to hand over. The first byte of a word is offered the cycle after its read data is acknowledged. The interrupt and the index update appear on the edge that accepts the write-back. Because the memory latency changes from test to test, the checks do not count fixed cycles. They wait for `tx_active` to fall, with a cycle limit, and only then compare the captured bytes, the flags in memory, `ring_idx` and `irq`. The interrupt clear and the idle-time index reset are sampled at the first falling edge after the edge that updates them.

// File: rtl/txr_pkg.sv
package txr_pkg;
   localparam int SZ_W  = 4;
   localparam int IDX_W = SZ_W + 2;
   localparam int CNT_W = 13;

   localparam int FLG_OWN      = 7;
   localparam int FLG_NOCRC    = 6;
   localparam int FLG_BADCRC   = 5;
   localparam int FLG_FORCE_UR = 3;
   localparam int FLG_SKIP     = 2;
   localparam int FLG_HW_UR    = 0;

   localparam int RA_CTRL    = 0;
   localparam int RA_BASE_HI = 1;
   localparam int RA_BASE_LO = 2;
   localparam int RA_SIZE    = 3;
   localparam int RA_PROMPT  = 4;
   localparam int RA_ICLR    = 5;

   typedef enum logic [2:0] {
      S_IDLE, S_DESC0, S_DESC1, S_FETCH, S_SEND, S_WBACK
   } txr_state_e;
endpackage

// File: rtl/txr_regs.sv
module txr_regs
   import txr_pkg::*;
#(
   parameter int REG_AW = 3,
   parameter int REG_DW = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [REG_DW-1:0] reg_wdata,
   input  logic              irq_set,
   input  logic              take_prompt,
   output logic              tx_en,
   output logic [5:0]        base_hi,
   output logic [15:0]       base_lo,
   output logic [SZ_W-1:0]   size_code,
   output logic              prompt_pend,
   output logic              irq
);
   logic wr_prompt, wr_iclr;
   assign wr_prompt = reg_wr && (reg_addr == REG_AW'(RA_PROMPT));
   assign wr_iclr   = reg_wr && (reg_addr == REG_AW'(RA_ICLR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_en       <= 1'b0;
         base_hi     <= '0;
         base_lo     <= '0;
         size_code   <= '0;
         prompt_pend <= 1'b0;
         irq         <= 1'b0;
      end else begin
         if (reg_wr && reg_addr == REG_AW'(RA_CTRL))    tx_en     <= reg_wdata[0];
         if (reg_wr && reg_addr == REG_AW'(RA_BASE_HI)) base_hi   <= reg_wdata[5:0];
         if (reg_wr && reg_addr == REG_AW'(RA_BASE_LO)) base_lo   <= reg_wdata[15:0];
         if (reg_wr && reg_addr == REG_AW'(RA_SIZE))    size_code <= reg_wdata[8 +: SZ_W];
         if (wr_prompt)        prompt_pend <= 1'b1;
         else if (take_prompt) prompt_pend <= 1'b0;
         if (irq_set)      irq <= 1'b1;
         else if (wr_iclr) irq <= 1'b0;
      end
   end
endmodule

// File: rtl/txr_ring_ptr.sv
module txr_ring_ptr
   import txr_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_en,
   input  logic             idle,
   input  logic             advance,
   input  logic [SZ_W-1:0]  size_code,
   input  logic [5:0]       base_hi,
   input  logic [15:0]      base_lo,
   output logic [IDX_W-1:0] ring_idx,
   output logic [31:0]      desc_addr
);
   localparam logic [31:0] TX_OFFSET = 32'd512;
   logic [IDX_W-1:0] last_idx;
   assign last_idx  = {size_code, 2'b11};
   assign desc_addr = {base_hi, base_lo, 10'b0} + TX_OFFSET + 32'({ring_idx, 3'b000});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ring_idx <= '0;
      else if (advance)
         ring_idx <= (!tx_en || ring_idx >= last_idx) ? '0 : ring_idx + 1'b1;
      else if (idle && !tx_en)
         ring_idx <= '0;
   end
endmodule

// File: rtl/txr_underrun.sv
module txr_underrun #(
   parameter int LIM = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic stall,
   output logic hit
);
   localparam int CW = (LIM < 1) ? 1 : $clog2(LIM + 1);

   generate
      if (LIM == 0) begin : g_off
         logic unused_in;
         assign unused_in = clk ^ rst_n ^ clear ^ stall;
         assign hit = 1'b0;
      end else begin : g_watch
         logic [CW-1:0] cnt;
         logic          hit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt   <= '0;
               hit_q <= 1'b0;
            end else if (clear) begin
               cnt   <= '0;
               hit_q <= 1'b0;
            end else if (stall) begin
               if (cnt == CW'(LIM - 1)) hit_q <= 1'b1;
               if (cnt != CW'(LIM))     cnt   <= cnt + 1'b1;
            end else begin
               cnt <= '0;
            end
         end
         assign hit = hit_q;
      end
   endgenerate
endmodule

// File: rtl/txr_engine.sv
module txr_engine
   import txr_pkg::*;
#(
   parameter int UNDER_LIM = 6,
   parameter int REG_AW    = 3,
   parameter int REG_DW    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [REG_DW-1:0] reg_wdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [31:0]       mem_addr,
   output logic [31:0]       mem_wdata,
   output logic [3:0]        mem_be,
   input  logic              mem_ack,
   input  logic [31:0]       mem_rdata,
   output logic              out_valid,
   output logic [7:0]        out_data,
   output logic              out_last,
   output logic              out_nocrc,
   output logic              out_badcrc,
   output logic              out_abort,
   input  logic              out_ready,
   output logic              tx_active,
   output logic [IDX_W-1:0]  ring_idx,
   output logic              irq
);
   initial begin
      if (REG_AW < 3)       $error("txr_engine: REG_AW must be at least 3");
      if (REG_DW < 16)      $error("txr_engine: REG_DW must be at least 16");
      if (UNDER_LIM > 255)  $error("txr_engine: UNDER_LIM out of range");
   end

   txr_state_e       state;
   logic             tx_en, prompt_pend, take_prompt, done_wb;
   logic             ur_hit, ur_clear, ur_stall, started;
   logic [5:0]       base_hi;
   logic [15:0]      base_lo;
   logic [SZ_W-1:0]  size_code;
   logic [31:0]      desc_addr, cur_addr, word_q;
   logic [CNT_W-1:0] left;
   logic [7:0]       flags, wb_flags;
   logic             unused_bits;

   assign unused_bits = ^mem_rdata[23:CNT_W];

   txr_regs #(.REG_AW(REG_AW), .REG_DW(REG_DW)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .irq_set(done_wb), .take_prompt(take_prompt),
      .tx_en(tx_en), .base_hi(base_hi), .base_lo(base_lo),
      .size_code(size_code), .prompt_pend(prompt_pend), .irq(irq)
   );

   txr_ring_ptr u_ptr (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .idle(state == S_IDLE),
      .advance(done_wb), .size_code(size_code), .base_hi(base_hi),
      .base_lo(base_lo), .ring_idx(ring_idx), .desc_addr(desc_addr)
   );

   txr_underrun #(.LIM(UNDER_LIM)) u_ur (
      .clk(clk), .rst_n(rst_n), .clear(ur_clear), .stall(ur_stall), .hit(ur_hit)
   );

   assign take_prompt = (state == S_IDLE) && tx_en && prompt_pend;
   assign done_wb     = (state == S_WBACK) && mem_ack;
   assign ur_clear    = (state == S_DESC1);
   assign ur_stall    = started && out_ready && (state == S_FETCH);
   assign tx_active   = (state != S_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         left     <= '0;
         flags    <= '0;
         cur_addr <= '0;
         word_q   <= '0;
         started  <= 1'b0;
      end else begin
         case (state)
            S_IDLE:  if (take_prompt) state <= S_DESC0;
            S_DESC0: if (mem_ack) begin
               if (mem_rdata[24 + FLG_OWN]) begin
                  flags <= mem_rdata[31:24];
                  left  <= mem_rdata[CNT_W-1:0];
                  state <= S_DESC1;
               end else begin
                  state <= S_IDLE;
               end
            end
            S_DESC1: if (mem_ack) begin
               cur_addr <= mem_rdata;
               started  <= 1'b0;
               state    <= (flags[FLG_SKIP] || left == '0) ? S_WBACK : S_FETCH;
            end
            S_FETCH: if (mem_ack) begin
               word_q <= mem_rdata;
               state  <= S_SEND;
            end
            S_SEND: if (out_ready) begin
               left     <= left - 1'b1;
               cur_addr <= cur_addr + 32'd1;
               started  <= 1'b1;
               if (left == CNT_W'(1))            state <= S_WBACK;
               else if (cur_addr[1:0] == 2'b11)  state <= S_FETCH;
            end
            S_WBACK: if (mem_ack) state <= tx_en ? S_DESC0 : S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      wb_flags = flags;
      wb_flags[FLG_OWN] = 1'b0;
      if (ur_hit) wb_flags[FLG_HW_UR] = 1'b1;
   end

   always_comb begin
      mem_req  = 1'b0;
      mem_we   = 1'b0;
      mem_addr = desc_addr;
      mem_be   = 4'b1111;
      case (state)
         S_DESC0: mem_req = 1'b1;
         S_DESC1: begin
            mem_req  = 1'b1;
            mem_addr = desc_addr + 32'd4;
         end
         S_FETCH: begin
            mem_req  = 1'b1;
            mem_addr = {cur_addr[31:2], 2'b00};
         end
         S_WBACK: begin
            mem_req = 1'b1;
            mem_we  = 1'b1;
            mem_be  = 4'b1000;
         end
         default: ;
      endcase
   end
   assign mem_wdata = {wb_flags, 24'h0};

   always_comb begin
      case (cur_addr[1:0])
         2'd0:    out_data = word_q[7:0];
         2'd1:    out_data = word_q[15:8];
         2'd2:    out_data = word_q[23:16];
         default: out_data = word_q[31:24];
      endcase
   end

   assign out_valid  = (state == S_SEND);
   assign out_last   = out_valid && (left == CNT_W'(1));
   assign out_nocrc  = out_valid && flags[FLG_NOCRC];
   assign out_badcrc = out_valid && flags[FLG_BADCRC];
   assign out_abort  = out_valid && flags[FLG_FORCE_UR];
endmodule

// File: rtl/txr_engine_chk.sv
module txr_engine_chk
   import txr_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic             out_valid,
   input logic             out_ready,
   input logic [7:0]       out_data,
   input logic             out_last,
   input logic             mem_req,
   input logic             mem_we,
   input logic             mem_ack,
   input logic [31:0]      mem_addr,
   input logic [31:0]      mem_wdata,
   input logic [3:0]       mem_be,
   input logic             irq,
   input logic             tx_active,
   input logic             tx_en,
   input logic [SZ_W-1:0]  size_code,
   input logic [IDX_W-1:0] ring_idx
);
   AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last))
      else $error("byte dropped while stalled"); // R4

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we))
      else $error("memory request withdrawn"); // R2

   AST_WB_FLAGS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> mem_be == 4'b1000 && !mem_wdata[31])
      else $error("write-back touches more than flags"); // R5

   AST_IRQ_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(mem_req && mem_we && mem_ack))
      else $error("interrupt without write-back"); // R5

   AST_IDX_ZERO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en && !tx_active |=> ring_idx == '0)
      else $error("index not reset while disabled"); // R11

   AST_IDX_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
      ring_idx <= {size_code, 2'b11})
      else $error("index beyond ring"); // R7
endmodule

bind txr_engine txr_engine_chk u_chk (
   .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
   .out_data(out_data), .out_last(out_last), .mem_req(mem_req), .mem_we(mem_we),
   .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
   .irq(irq), .tx_active(tx_active), .tx_en(tx_en), .size_code(size_code),
   .ring_idx(ring_idx)
);

// File: tb/tb_txr_engine.sv
`timescale 1ns/1ps
module tb_txr_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic        mem_req, mem_we, mem_ack;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic [3:0]  mem_be;
   logic        out_valid, out_last, out_nocrc, out_badcrc, out_abort;
   logic        out_ready = 1'b1;
   logic [7:0]  out_data;
   logic        tx_active, irq;
   logic [5:0]  ring_idx;

   always #2 clk = ~clk;

   txr_engine dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .out_valid(out_valid),
      .out_data(out_data), .out_last(out_last), .out_nocrc(out_nocrc),
      .out_badcrc(out_badcrc), .out_abort(out_abort), .out_ready(out_ready),
      .tx_active(tx_active), .ring_idx(ring_idx), .irq(irq)
   );

   int n_chk = 0;
   int n_bad = 0;
   logic [7:0]  mem [0:4095];
   int          lat = 0;
   int          lat_cnt = 0;
   int          ma;
   logic [31:0] last_rd_addr = '0;
   logic [7:0]  cap [0:511];
   logic [3:0]  capflg [0:511];
   int          ncap = 0;
   bit          toggle_ready = 1'b0;
   int          cyc = 0;

   // memory model
   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack   <= 1'b0;
         mem_rdata <= '0;
         lat_cnt   = 0;
      end else begin
         mem_ack <= 1'b0;
         if (mem_req && !mem_ack) begin
            if (lat_cnt >= lat) begin
               lat_cnt = 0;
               mem_ack <= 1'b1;
               ma = int'(mem_addr[11:0]);
               if (mem_we) begin
                  for (int b = 0; b < 4; b++)
                     if (mem_be[b]) mem[ma + b] = mem_wdata[8*b +: 8];
               end else begin
                  mem_rdata <= {mem[ma+3], mem[ma+2], mem[ma+1], mem[ma]};
                  last_rd_addr = mem_addr;
               end
            end else begin
               lat_cnt = lat_cnt + 1;
            end
         end
      end
   end

   // framer model
   always @(posedge clk) begin
      if (rst_n && out_valid && out_ready && ncap < 512) begin
         cap[ncap]    = out_data;
         capflg[ncap] = {out_last, out_nocrc, out_badcrc, out_abort};
         ncap = ncap + 1;
      end
   end
   always @(negedge clk) begin
      cyc <= cyc + 1;
      out_ready <= toggle_ready ? ((cyc % 3) != 0) : 1'b1;
   end

   task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic reg_write(input int a, input int d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = 16'(d);
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic put_desc(input int idx, input int cnt, input logic [7:0] flg, input logic [31:0] baddr);
      int a = 'h600 + idx * 8;
      mem[a]   = cnt[7:0];
      mem[a+1] = {3'b000, cnt[12:8]};
      mem[a+2] = 8'h00;
      mem[a+3] = flg;
      for (int k = 0; k < 4; k++) mem[a+4+k] = baddr[8*k +: 8];
   endtask

   task automatic fill_buf(input int addr, input int n, input int seed);
      for (int i = 0; i < n; i++) mem[addr + i] = 8'(seed + i * 7);
   endtask

   task automatic wait_done(input string req);
      int t = 0;
      repeat (3) @(negedge clk);
      while (tx_active && t < 20000) begin
         @(negedge clk);
         t++;
      end
      chk_eq({req, " completes"}, 32'(tx_active), 32'd0);
      repeat (2) @(negedge clk);
   endtask

   task automatic check_bytes(input string req, input int start, input int addr, input int n);
      int bad = 0;
      int lasts = 0;
      for (int i = 0; i < n; i++) begin
         if (cap[start + i] !== mem[addr + i]) bad++;
         if (capflg[start + i][3]) lasts++;
      end
      chk_eq({req, " payload mismatches"}, 32'(bad), 32'd0);
      chk_eq({req, " single last marker"}, 32'(lasts), 32'd1);
      chk_eq({req, " last on final byte"}, 32'(capflg[start + n - 1][3]), 32'd1);
   endtask

   task automatic t_reset;
      chk_eq("R1 irq", 32'(irq), 0);
      chk_eq("R1 tx_active", 32'(tx_active), 0);
      chk_eq("R1 mem_req", 32'(mem_req), 0);
      chk_eq("R1 out_valid", 32'(out_valid), 0);
      chk_eq("R1 ring_idx", 32'(ring_idx), 0);
   endtask

   task automatic t_unowned;
      put_desc(0, 4, 8'h00, 32'h800);
      reg_write(4, 0);
      repeat (20) @(negedge clk);
      chk_eq("R3 unowned sends nothing", 32'(ncap), 0);
      chk_eq("R3 unowned no irq", 32'(irq), 0);
      chk_eq("R3 unowned index", 32'(ring_idx), 0);
      chk_eq("R3 unowned flags untouched", 32'(mem['h603]), 0);
      chk_eq("R2 descriptor address", last_rd_addr, 32'h600);
   endtask

   task automatic t_prompt;
      fill_buf('h800, 3, 1);
      put_desc(0, 3, 8'h80, 32'h800);
      repeat (20) @(negedge clk);
      chk_eq("R3 no fetch without prompt", 32'(ncap), 0);
      reg_write(4, 'h55);
      wait_done("R3");
      chk_eq("R4 byte count", 32'(ncap), 3);
      check_bytes("R4 basic", 0, 'h800, 3);
      chk_eq("R5 flags written back", 32'(mem['h603]), 32'h00);
      chk_eq("R5 count bytes kept", 32'(mem['h600]), 3);
      chk_eq("R5 irq raised", 32'(irq), 1);
      chk_eq("R2 index advanced", 32'(ring_idx), 1);
      reg_write(5, 0);
      chk_eq("R5 irq cleared", 32'(irq), 0);
   endtask

   task automatic t_long;
      ncap = 0;
      toggle_ready = 1'b1;
      fill_buf('h903, 261, 3);
      put_desc(1, 261, 8'h80, 32'h903);
      reg_write(4, 0);
      wait_done("R4");
      toggle_ready = 1'b0;
      chk_eq("R4 13-bit count", 32'(ncap), 261);
      check_bytes("R4 unaligned stalled", 0, 'h903, 261);
      chk_eq("R4 index", 32'(ring_idx), 2);
      reg_write(5, 0);
   endtask

   task automatic t_chain;
      ncap = 0;
      fill_buf('hB00, 4, 9);
      fill_buf('hB11, 6, 21);
      put_desc(2, 4, 8'h80, 32'hB00);
      put_desc(3, 6, 8'h80, 32'hB11);
      put_desc(4, 2, 8'h00, 32'hB40);
      reg_write(4, 0);
      wait_done("R6");
      chk_eq("R6 chained byte count", 32'(ncap), 10);
      check_bytes("R6 first", 0, 'hB00, 4);
      check_bytes("R6 second", 4, 'hB11, 6);
      chk_eq("R6 stops at unowned", 32'(ring_idx), 4);
      chk_eq("R6 second written back", 32'(mem['h600 + 3*8 + 3]), 0);
      reg_write(5, 0);
   endtask

   task automatic t_skip;
      ncap = 0;
      put_desc(4, 5, 8'h84, 32'hC00);
      put_desc(5, 0, 8'h80, 32'hC00);
      reg_write(4, 0);
      wait_done("R8");
      chk_eq("R8 no bytes", 32'(ncap), 0);
      chk_eq("R8 skip written back", 32'(mem['h600 + 4*8 + 3]), 32'h04);
      chk_eq("R8 zero count written back", 32'(mem['h600 + 5*8 + 3]), 32'h00);
      chk_eq("R8 irq", 32'(irq), 1);
      chk_eq("R8 index", 32'(ring_idx), 6);
      reg_write(5, 0);
   endtask

   task automatic t_side;
      int bad = 0;
      ncap = 0;
      fill_buf('hC40, 3, 40);
      put_desc(6, 3, 8'hE8, 32'hC40);
      reg_write(4, 0);
      wait_done("R9");
      chk_eq("R9 byte count", 32'(ncap), 3);
      for (int i = 0; i < 3; i++) if (capflg[i][2:0] != 3'b111) bad++;
      chk_eq("R9 sideband on every byte", 32'(bad), 0);
      chk_eq("R9 flags kept on write-back", 32'(mem['h600 + 6*8 + 3]), 32'h68);
      reg_write(5, 0);
   endtask

   task automatic t_under;
      ncap = 0;
      lat = 12;
      fill_buf('hD00, 8, 77);
      put_desc(7, 8, 8'h80, 32'hD00);
      reg_write(4, 0);
      wait_done("R10");
      lat = 0;
      check_bytes("R10 payload", 0, 'hD00, 8);
      chk_eq("R10 hardware underrun flagged", 32'(mem['h600 + 7*8 + 3]), 32'h01);
      reg_write(5, 0);
   endtask

   task automatic t_disable;
      int t = 0;
      ncap = 0;
      lat = 2;
      fill_buf('hE00, 40, 5);
      put_desc(8, 40, 8'h80, 32'hE00);
      put_desc(9, 2, 8'h80, 32'hF00);
      reg_write(4, 0);
      while (ncap < 5 && t < 2000) begin
         @(negedge clk);
         t++;
      end
      reg_write(0, 0);
      wait_done("R11");
      lat = 0;
      chk_eq("R11 current frame finishes", 32'(ncap), 40);
      chk_eq("R11 next entry not taken", 32'(mem['h600 + 9*8 + 3]), 32'h80);
      chk_eq("R11 index zero", 32'(ring_idx), 0);
      chk_eq("R11 idle", 32'(tx_active), 0);
      reg_write(5, 0);
   endtask

   task automatic t_wrap;
      ncap = 0;
      reg_write(3, 'h000);
      reg_write(0, 1);
      for (int i = 0; i < 4; i++) begin
         mem['hF80 + i] = 8'(8'hA0 + i);
         put_desc(i, 1, 8'h80, 32'(32'hF80 + i));
      end
      reg_write(4, 0);
      wait_done("R7");
      chk_eq("R7 four entries sent", 32'(ncap), 4);
      chk_eq("R7 last byte from entry 3", 32'(cap[3]), 32'hA3);
      chk_eq("R7 index wrapped", 32'(ring_idx), 0);
      chk_eq("R7 entry 0 re-read after wrap", last_rd_addr, 32'h600);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      reg_write(1, 'h00);
      reg_write(2, 'h01);
      reg_write(3, 'h300);
      reg_write(0, 1);
      t_unowned;
      t_prompt;
      t_long;
      t_chain;
      t_skip;
      t_side;
      t_under;
      t_disable;
      t_wrap;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule